// File: doc/BRIEF.md
# Slot-Scheduled Bus Arbiter with Idle-Slot Reclaim

This block decides which of several bus masters may drive a shared bus. Time is cut into slots of equal, configurable length. A small schedule table, walked in a loop, names the master that owns each slot. A master that needs more bandwidth can own more than one entry. When the owner of the coming slot is asking for the bus, it gets the slot. When the owner is idle, a second stage offers the slot to the other masters in rotating order, so that the slot is not wasted.

Each master has one request line and one grant line. The grant is decided at the slot boundary and then held, unchanged, for every cycle of the slot. A transfer is never cut short inside a slot, even if its request drops. The schedule table, the slot length and the number of active table entries are written through plain write-enable ports. Writes land in a shadow copy. The schedule in use takes the shadow copy only when the table walk wraps back to entry 0. There is no stream data path, so every pin is a plain control pin.

Top module: `tdma_rr_arbiter`

## Requirements
- R1: While reset is active, and in the first cycle after it, `grant` is all zero. Out of reset, the table holds owner `i mod 4` at entry `i`, the slot length is 4 cycles (code 3), and 4 entries are active (code 3).
- R2: If the owner of the next slot has its `req` bit high in the boundary cycle, then for the whole slot `grant` is one-hot on that owner.
- R3: If the owner is idle at the boundary, the slot goes to the first requesting master found by searching upward, with wrap-around, from the master after the last one that won a reclaimed slot. The pointer moves only when a reclaim is granted, and after reset the search starts at master 0.
- R4: If no master requests at the boundary, `grant` stays zero for that slot.
- R5: At most one bit of `grant` is high in any cycle.
- R6: A nonzero grant always goes to a master whose `req` bit was high in the boundary cycle that decided it.
- R7: A slot lasts `cfg_len_data + 1` cycles (1 to 16). `grant` changes only on the first cycle of a slot.
- R8: The table walk visits entries 0 to `cfg_cnt_data` in order and then returns to entry 0 (1 to 8 entries).
- R9: A write to the table, the length or the count does not affect the schedule until the next boundary at which the walk returns to entry 0. A write made in that same boundary cycle waits for the following wrap.
- R10: If the table owner never requests, every other master that keeps requesting receives a slot within N-1 slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 4 | One request bit per master |
| grant | output | 4 | One grant bit per master, one-hot or zero |
| cfg_tab_we | input | 1 | Write strobe for one schedule table entry |
| cfg_tab_addr | input | 3 | Table entry to write |
| cfg_tab_data | input | 2 | Master number stored at that entry |
| cfg_len_we | input | 1 | Write strobe for the slot length |
| cfg_len_data | input | 4 | Slot length minus one |
| cfg_cnt_we | input | 1 | Write strobe for the active entry count |
| cfg_cnt_data | input | 3 | Number of active table entries minus one |

## Verification
Two things can happen in the same boundary cycle: the walk wraps and loads the shadow configuration, and a new configuration write arrives. The bench places writes on exactly such cycles as well as in the middle of slots, and its model requires the write to wait one more table cycle. The other case is a boundary where the owner is idle and the round-robin pointer chooses a master. Here random request patterns are judged against a bench model that tracks the pointer and the slot owner, cycle by cycle, from the requirements.

// File: rtl/tdma_arb_pkg.sv
package tdma_arb_pkg;
  // cyclic distance helper used by the rotating search
  function automatic int wrap_add(input int base, input int step, input int n);
    return (base + step) % n;
  endfunction
endpackage

// File: rtl/tdma_slot_seq.sv
module tdma_slot_seq #(
  parameter int N_MST = 4,
  parameter int DEPTH = 8,
  parameter int LEN_W = 4,
  localparam int OW = $clog2(N_MST),
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tab_we,
  input  logic [IW-1:0] tab_addr,
  input  logic [OW-1:0] tab_data,
  input  logic          len_we,
  input  logic [LEN_W-1:0] len_data,
  input  logic          cnt_we,
  input  logic [IW-1:0] cnt_data,
  output logic          boundary,
  output logic [OW-1:0] owner_nxt
);
  localparam int CNT_RST = (N_MST <= DEPTH) ? N_MST - 1 : DEPTH - 1;
  localparam int LEN_RST = ((1 << LEN_W) > 3) ? 3 : 0;

  logic [OW-1:0]    sh_tab  [DEPTH];
  logic [OW-1:0]    act_tab [DEPTH];
  logic [LEN_W-1:0] sh_len, act_len, left, len_nxt;
  logic [IW-1:0]    sh_cnt, act_cnt, idx, idx_nxt;
  logic             wrap;

  assign boundary  = (left == '0);
  assign wrap      = (idx == act_cnt);
  assign idx_nxt   = wrap ? '0 : idx + IW'(1);
  assign owner_nxt = wrap ? sh_tab[0] : act_tab[idx_nxt];
  assign len_nxt   = wrap ? sh_len : act_len;

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_tab[e]  <= OW'(e % N_MST);
        act_tab[e] <= OW'(e % N_MST);
      end else begin
        if (boundary && wrap) act_tab[e] <= sh_tab[e];
        if (tab_we && tab_addr == IW'(e)) sh_tab[e] <= tab_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_len  <= LEN_W'(LEN_RST);
      sh_cnt  <= IW'(CNT_RST);
      act_len <= LEN_W'(LEN_RST);
      act_cnt <= IW'(CNT_RST);
      idx     <= IW'(CNT_RST);
      left    <= '0;
    end else begin
      if (boundary) begin
        idx  <= idx_nxt;
        left <= len_nxt;
        if (wrap) begin
          act_len <= sh_len;
          act_cnt <= sh_cnt;
        end
      end else begin
        left <= left - LEN_W'(1);
      end
      if (len_we) sh_len <= len_data;
      if (cnt_we) sh_cnt <= cnt_data;
    end
  end
endmodule

// File: rtl/tdma_rr_pick.sv
module tdma_rr_pick #(
  parameter int N_MST = 4,
  localparam int OW = $clog2(N_MST)
) (
  input  logic [N_MST-1:0] req,
  input  logic [OW-1:0]    last,
  output logic             found,
  output logic [OW-1:0]    pick
);
  // scan from farthest to nearest so the nearest requester wins
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = N_MST; k >= 1; k--) begin
      if (req[tdma_arb_pkg::wrap_add(int'(last), k, N_MST)]) begin
        found = 1'b1;
        pick  = OW'(tdma_arb_pkg::wrap_add(int'(last), k, N_MST));
      end
    end
  end
endmodule

// File: rtl/tdma_grant_sel.sv
module tdma_grant_sel #(
  parameter int N_MST = 4,
  localparam int OW = $clog2(N_MST)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boundary,
  input  logic [OW-1:0]    owner_nxt,
  input  logic [N_MST-1:0] req,
  output logic [N_MST-1:0] grant
);
  logic [OW-1:0] rr_last, pick;
  logic          found;

  tdma_rr_pick #(.N_MST(N_MST)) u_pick (
    .req(req), .last(rr_last), .found(found), .pick(pick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant   <= '0;
      rr_last <= OW'(N_MST - 1);
    end else if (boundary) begin
      if (req[owner_nxt]) begin
        grant <= N_MST'(1) << owner_nxt;
      end else if (found) begin
        grant   <= N_MST'(1) << pick;
        rr_last <= pick;
      end else begin
        grant <= '0;
      end
    end
  end
endmodule

// File: rtl/tdma_rr_arbiter.sv
module tdma_rr_arbiter #(
  parameter int N_MST = 4,
  parameter int DEPTH = 8,
  parameter int LEN_W = 4,
  localparam int OW = $clog2(N_MST),
  localparam int IW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_MST-1:0] req,
  output logic [N_MST-1:0] grant,
  input  logic             cfg_tab_we,
  input  logic [IW-1:0]    cfg_tab_addr,
  input  logic [OW-1:0]    cfg_tab_data,
  input  logic             cfg_len_we,
  input  logic [LEN_W-1:0] cfg_len_data,
  input  logic             cfg_cnt_we,
  input  logic [IW-1:0]    cfg_cnt_data
);
  logic          boundary;
  logic [OW-1:0] owner_nxt;

  tdma_slot_seq #(.N_MST(N_MST), .DEPTH(DEPTH), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .tab_we(cfg_tab_we), .tab_addr(cfg_tab_addr), .tab_data(cfg_tab_data),
    .len_we(cfg_len_we), .len_data(cfg_len_data),
    .cnt_we(cfg_cnt_we), .cnt_data(cfg_cnt_data),
    .boundary(boundary), .owner_nxt(owner_nxt)
  );

  tdma_grant_sel #(.N_MST(N_MST)) u_sel (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .owner_nxt(owner_nxt),
    .req(req), .grant(grant)
  );
endmodule

// File: rtl/tdma_rr_arbiter_chk.sv
module tdma_rr_arbiter_chk #(
  parameter int N_MST = 4,
  localparam int OW = $clog2(N_MST)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_MST-1:0] req,
  input logic [N_MST-1:0] grant,
  input logic             boundary,
  input logic [OW-1:0]    owner_nxt
);
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R5
  AST_HOLD_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(boundary) |-> $stable(grant)); // R7
  AST_OWNER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    boundary && req[owner_nxt] |=> grant == (N_MST'(1) << $past(owner_nxt))); // R2
  AST_GRANT_BACKED: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (grant == '0) || ((grant & $past(req)) != '0)); // R6
  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    boundary && (req == '0) |=> grant == '0); // R4
endmodule

bind tdma_rr_arbiter tdma_rr_arbiter_chk #(.N_MST(N_MST)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .grant(grant),
  .boundary(boundary), .owner_nxt(owner_nxt)
);

// File: tb/tb_tdma_rr_arbiter.sv
module tb_tdma_rr_arbiter;
  localparam int CLK_NS = 20;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] req = '0;
  logic [3:0] grant;
  logic tab_we = 0, len_we = 0, cnt_we = 0;
  logic [2:0] tab_addr = '0, cnt_data = '0;
  logic [1:0] tab_data = '0;
  logic [3:0] len_data = '0;
  int errors = 0, checks = 0;
  bit done = 0;
  string tag = "R1";

  always #(CLK_NS/2) clk = ~clk;

  tdma_rr_arbiter dut (
    .clk(clk), .rst_n(rst_n), .req(req), .grant(grant),
    .cfg_tab_we(tab_we), .cfg_tab_addr(tab_addr), .cfg_tab_data(tab_data),
    .cfg_len_we(len_we), .cfg_len_data(len_data),
    .cfg_cnt_we(cnt_we), .cfg_cnt_data(cnt_data)
  );

  // reference model built from the requirements
  logic [1:0] m_sh [8], m_act [8];
  int m_sh_len, m_act_len, m_sh_cnt, m_act_cnt, m_left, m_idx, m_rr;
  logic [3:0] m_grant;
  int wins [4];

  task automatic model_reset();
    for (int e = 0; e < 8; e++) begin m_sh[e] = 2'(e % 4); m_act[e] = 2'(e % 4); end
    m_sh_len = 3; m_act_len = 3; m_sh_cnt = 3; m_act_cnt = 3;
    m_idx = 3; m_left = 0; m_rr = 3; m_grant = '0;
  endtask

  task automatic model_edge();
    if (m_left == 0) begin
      int own;
      if (m_idx == m_act_cnt) begin
        for (int e = 0; e < 8; e++) m_act[e] = m_sh[e];
        m_act_len = m_sh_len; m_act_cnt = m_sh_cnt; m_idx = 0;
      end else m_idx++;
      m_left = m_act_len;
      own = int'(m_act[m_idx]);
      m_grant = '0;
      if (req[own]) m_grant[own] = 1'b1;
      else begin
        for (int k = 1; k <= 4; k++)
          if (m_grant == '0 && req[(m_rr + k) % 4]) begin
            m_rr = (m_rr + k) % 4; m_grant[m_rr] = 1'b1;
          end
      end
    end else m_left--;
    if (tab_we) m_sh[tab_addr] = tab_data;
    if (len_we) m_sh_len = int'(len_data);
    if (cnt_we) m_sh_cnt = int'(cnt_data);
  endtask

  task automatic check(input string t, input bit ok, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", t, act, exp, $time);
    end
  endtask

  // one clock: model advances, outputs compared after the edge
  task automatic cyc();
    @(posedge clk);
    model_edge();
    #2;
    check(tag, grant === m_grant, grant, m_grant);
    check("R5", $countones(grant) <= 1, grant, m_grant);
    for (int m = 0; m < 4; m++) if (grant[m]) wins[m]++;
    tab_we = 0; len_we = 0; cnt_we = 0;
  endtask

  task automatic run(input int n, input bit rnd, input logic [3:0] fixed);
    for (int i = 0; i < n; i++) begin
      req = rnd ? 4'($urandom) : fixed;
      cyc();
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    #(CLK_NS*3);
    check("R1", grant === 4'b0, grant, 4'b0);       // R1 during reset
    @(negedge clk); rst_n = 1'b1; req = 4'b1111;
    tag = "R1"; cyc();                                // first cycle out of reset
    tag = "R2"; run(40, 0, 4'b1111);
    tag = "R4"; run(20, 0, 4'b0000);
    tag = "R3"; run(40, 0, 4'b0100);
    run(300, 1, '0);
    // writes spread over random cycles, incl. wrap boundaries
    tag = "R9";
    for (int i = 0; i < 8; i++) begin
      tab_we = 1; tab_addr = 3'(i); tab_data = 2'($urandom);
      len_we = 1; len_data = 4'($urandom % 3);
      cnt_we = 1; cnt_data = 3'($urandom);
      req = 4'($urandom); cyc();
      run(int'($urandom % 9), 1, '0);
    end
    run(80, 1, '0);
    tag = "R7";
    len_we = 1; len_data = 4'd15; cnt_we = 1; cnt_data = 3'd7; req = 4'($urandom); cyc();
    run(400, 1, '0);
    tag = "R8";
    len_we = 1; len_data = 4'd0; cnt_we = 1; cnt_data = 3'd0;
    tab_we = 1; tab_addr = 3'd0; tab_data = 2'd0; req = 4'($urandom); cyc();
    run(150, 1, '0);
    // owner 0 never requests, others must all be served
    tag = "R10";
    for (int m = 0; m < 4; m++) wins[m] = 0;
    run(48, 0, 4'b1110);
    for (int m = 1; m < 4; m++) check("R10", wins[m] > 0, 4'(m), 4'(m));
    check("R10", wins[0] == 0, 4'(wins[0]), 4'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_NS*200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule